// File: doc/BRIEF.md
# Associative Spill Value Store

This block keeps register values that the compiler has spilled and whose spill instruction has retired. Each value is tagged with its spill name, a virtual address. Entries live in a small fully associative array, so a later fill can find its value on chip and skip a memory read. Retiring spills write through a commit port. Retiring kills and fill-with-kill operations drop the matching entry through an invalidate port, so a dead value never reaches memory. A fill queries the lookup port by name and gets a hit flag and data in the same cycle.

Values leave for memory only when they have to. A new name that finds the array full evicts the least recently used entry. When occupancy rises above a programmable watermark, idle cycles are used to push out LRU entries early, so that later spills do not stall. A flush request drains every valid entry before the address space is reused. All evictions go through a single registered write port with a valid/ready handshake, and each one carries the spill name as its memory address.

Top module: `spill_value_store`

## Requirements
- R1: A lookup compares `lookup_name_i` against every valid entry in the same cycle. On a match it drives `lookup_hit_o`=1 and that entry's value on `lookup_data_o`. On no match, `lookup_hit_o`=0 and `lookup_data_o`=0.
- R2: A commit of a name that is not present, while an entry is free, stores the name and value in a free entry and causes no eviction.
- R3: A commit of a name that is already present overwrites the value in place. It allocates no second entry and causes no eviction, even when the store is full.
- R4: A kill whose name matches an entry invalidates that entry and writes nothing to memory.
- R5: A commit and a kill of the same name in the same cycle act as commit-then-kill: afterwards the name is absent, and nothing is written to memory.
- R6: A commit of a new name into a full store evicts the least recently used entry through the eviction port, with `evict_addr_o` set to its name and `evict_data_o` to its value. Recency is refreshed by a commit to an entry and by a lookup hit on it.
- R7: When the store is full, the commit name is new, and the eviction port holds an unaccepted word (`evict_valid_o`=1, `evict_ready_i`=0), `commit_ready_o` is 0. It returns to 1 in the cycle `evict_ready_i` rises.
- R8: In a cycle with no accepted commit, no kill and no pending eviction word, the store evicts the LRU entry if occupancy is strictly greater than `hiwater_i`. It stops once occupancy is at or below `hiwater_i`.
- R9: A one-cycle pulse on `flush_req_i` raises `flush_busy_o` from the next cycle. While busy, commits are refused. All valid entries are written out, and `flush_busy_o` falls only once the store is empty and the eviction port is drained.
- R10: After reset the store is empty: `lookup_hit_o`=0, `evict_valid_o`=0, `flush_busy_o`=0, `commit_ready_o`=1.
- R11: While `evict_valid_o`=1 and `evict_ready_i`=0, `evict_valid_o`, `evict_addr_o` and `evict_data_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_valid_i | input | 1 | Retiring spill present |
| commit_ready_o | output | 1 | Commit accepted this cycle |
| commit_name_i | input | NAME_W | Spill name of the commit |
| commit_data_i | input | DATA_W | Spilled value |
| kill_valid_i | input | 1 | Retiring kill or fill-with-kill present |
| kill_name_i | input | NAME_W | Name to invalidate |
| lookup_name_i | input | NAME_W | Name queried by a fill |
| lookup_hit_o | output | 1 | Query matched a valid entry |
| lookup_data_o | output | DATA_W | Value of the matching entry, zero on a miss |
| hiwater_i | input | CNT_W | Occupancy watermark for early eviction |
| flush_req_i | input | 1 | Drain all entries to memory |
| flush_busy_o | output | 1 | Drain in progress |
| evict_valid_o | output | 1 | Eviction word valid |
| evict_ready_i | input | 1 | Memory accepts the eviction word |
| evict_addr_o | output | NAME_W | Eviction address (spill name) |
| evict_data_o | output | DATA_W | Evicted value |

## Verification
The embedded properties are checked on every cycle. They cover: no name ever holding two entries, a kill really clearing its entry, the LRU victim always being a valid entry, a touched entry becoming most recent, commit stalls occurring only for a blocked port or a flush, the eviction word holding under backpressure, and a flush ending with an empty store. What the properties cannot show is which name gets evicted after a given mix of commits and lookup hits. The same holds for whether a kill or a same-cycle commit-and-kill truly kept a value off the memory port, how far the watermark drains the store, and what a lookup returns after an overwrite. The bench's scenarios establish these from the port traffic.

// File: rtl/svs_pkg.sv
package svs_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_CAP  = 2'd1,
    EV_BG   = 2'd2
  } ev_src_e;
endpackage

// File: rtl/svs_match.sv
module svs_match #(
  parameter int N      = 64,
  parameter int NAME_W = 32,
  localparam int IW    = $clog2(N)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              valid_i,
  input  logic [N-1:0][NAME_W-1:0]  names_i,
  input  logic [NAME_W-1:0]         key_i,
  output logic                      hit_o,
  output logic [IW-1:0]             idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (names_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) if (match[i]) idx_o = IW'(i);
  end
  assign hit_o = |match;

  // a name never occupies two entries
  p_unique_name_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(match));
endmodule

// File: rtl/svs_pick_first.sv
module svs_pick_first #(
  parameter int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) if (req_i[i]) idx_o = IW'(i);
  end
  assign any_o = |req_i;
endmodule

// File: rtl/svs_lru.sv
module svs_lru #(
  parameter int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  valid_i,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] victim_o
);
  // ages form a permutation of 0..N-1; larger is older
  logic [N-1:0][IW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx_i)             age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic          found;
    logic [IW-1:0] best;
    found    = 1'b0;
    best     = '0;
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && (!found || age_q[i] > best)) begin
        found    = 1'b1;
        best     = age_q[i];
        victim_o = IW'(i);
      end
    end
  end

  p_victim_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|valid_i) |-> valid_i[victim_o]);
  p_touch_mru_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/spill_value_store.sv
module spill_value_store
  import svs_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int NAME_W      = 32,
  parameter int DATA_W      = 64,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_valid_i,
  output logic              commit_ready_o,
  input  logic [NAME_W-1:0] commit_name_i,
  input  logic [DATA_W-1:0] commit_data_i,
  input  logic              kill_valid_i,
  input  logic [NAME_W-1:0] kill_name_i,
  input  logic [NAME_W-1:0] lookup_name_i,
  output logic              lookup_hit_o,
  output logic [DATA_W-1:0] lookup_data_o,
  input  logic [CNT_W-1:0]  hiwater_i,
  input  logic              flush_req_i,
  output logic              flush_busy_o,
  output logic              evict_valid_o,
  input  logic              evict_ready_i,
  output logic [NAME_W-1:0] evict_addr_o,
  output logic [DATA_W-1:0] evict_data_o
);
  localparam int N = NUM_ENTRIES;

  logic [N-1:0]             valid_q;
  logic [N-1:0][NAME_W-1:0] name_q;
  logic [N-1:0][DATA_W-1:0] data_q;
  logic                     ev_valid_q, flush_q;
  logic [NAME_W-1:0]        ev_addr_q;
  logic [DATA_W-1:0]        ev_data_q;

  logic             l_hit, c_hit, k_hit, free_any;
  logic [IDX_W-1:0] l_idx, c_idx, k_idx, free_idx, victim, wr_idx, touch_idx;
  logic             same_kill, can_load, commit_fire, cap_evict, bg_evict, touch;
  logic [CNT_W-1:0] occ;
  ev_src_e          ev_src;

  svs_match #(.N(N), .NAME_W(NAME_W)) i_match_lookup (
    .clk_i, .rst_ni, .valid_i(valid_q), .names_i(name_q), .key_i(lookup_name_i),
    .hit_o(l_hit), .idx_o(l_idx));
  svs_match #(.N(N), .NAME_W(NAME_W)) i_match_commit (
    .clk_i, .rst_ni, .valid_i(valid_q), .names_i(name_q), .key_i(commit_name_i),
    .hit_o(c_hit), .idx_o(c_idx));
  svs_match #(.N(N), .NAME_W(NAME_W)) i_match_kill (
    .clk_i, .rst_ni, .valid_i(valid_q), .names_i(name_q), .key_i(kill_name_i),
    .hit_o(k_hit), .idx_o(k_idx));

  svs_pick_first #(.N(N)) i_free (.req_i(~valid_q), .any_o(free_any), .idx_o(free_idx));

  svs_lru #(.N(N)) i_lru (
    .clk_i, .rst_ni, .valid_i(valid_q), .touch_i(touch), .touch_idx_i(touch_idx),
    .victim_o(victim));

  always_comb begin
    occ = '0;
    for (int i = 0; i < N; i++) occ = occ + CNT_W'(valid_q[i]);
  end

  assign same_kill      = commit_valid_i && kill_valid_i && (commit_name_i == kill_name_i);
  assign can_load       = !ev_valid_q || evict_ready_i;
  assign commit_ready_o = !flush_q && (c_hit || free_any || same_kill || can_load);
  assign commit_fire    = commit_valid_i && commit_ready_o;
  assign cap_evict      = commit_fire && !same_kill && !c_hit && !free_any;
  assign wr_idx         = c_hit ? c_idx : (free_any ? free_idx : victim);
  assign bg_evict       = !commit_fire && !kill_valid_i && !ev_valid_q && (|valid_q)
                          && (flush_q || occ > hiwater_i);

  always_comb begin
    ev_src = EV_NONE;
    // a victim killed in the same cycle is simply overwritten, never written out
    if (cap_evict && !(kill_valid_i && k_hit && k_idx == victim)) ev_src = EV_CAP;
    else if (bg_evict)                                            ev_src = EV_BG;
  end

  assign touch     = (commit_fire && !same_kill) || l_hit;
  assign touch_idx = (commit_fire && !same_kill) ? wr_idx : l_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      name_q     <= '0;
      data_q     <= '0;
      ev_valid_q <= 1'b0;
      ev_addr_q  <= '0;
      ev_data_q  <= '0;
      flush_q    <= 1'b0;
    end else begin
      if (kill_valid_i && k_hit) valid_q[k_idx] <= 1'b0;
      if (ev_src == EV_BG)       valid_q[victim] <= 1'b0;
      if (commit_fire && !same_kill) begin
        valid_q[wr_idx] <= 1'b1;
        name_q[wr_idx]  <= commit_name_i;
        data_q[wr_idx]  <= commit_data_i;
      end
      if (ev_src != EV_NONE) begin
        ev_valid_q <= 1'b1;
        ev_addr_q  <= name_q[victim];
        ev_data_q  <= data_q[victim];
      end else if (evict_ready_i) begin
        ev_valid_q <= 1'b0;
      end
      if (flush_req_i)                              flush_q <= 1'b1;
      else if (flush_q && !(|valid_q) && !ev_valid_q) flush_q <= 1'b0;
    end
  end

  assign lookup_hit_o  = l_hit;
  assign lookup_data_o = l_hit ? data_q[l_idx] : '0;
  assign flush_busy_o  = flush_q;
  assign evict_valid_o = ev_valid_q;
  assign evict_addr_o  = ev_addr_q;
  assign evict_data_o  = ev_data_q;

  p_kill_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_valid_i && k_hit && !(commit_fire && !same_kill && wr_idx == k_idx))
    |=> !valid_q[$past(k_idx)]);
  p_commit_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_ready_o |-> (flush_busy_o || (evict_valid_o && !evict_ready_i)));
  p_flush_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_busy_o) |-> (valid_q == '0 && !evict_valid_o));
  p_flush_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_busy_o |-> !commit_ready_o);
  p_evict_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_o && !evict_ready_i)
    |=> (evict_valid_o && $stable(evict_addr_o) && $stable(evict_data_o)));
endmodule

// File: tb/test_spill_value_store.sv
module test_spill_value_store;
  localparam int N = 4;
  localparam int NW = 16;
  localparam int DW = 16;
  localparam int CW = $clog2(N + 1);
  localparam logic [15:0] IDLE_NAME = 16'hFFFF;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic commit_valid_i = 1'b0, kill_valid_i = 1'b0, flush_req_i = 1'b0, evict_ready_i = 1'b1;
  logic [NW-1:0] commit_name_i = '0, kill_name_i = '0, lookup_name_i = IDLE_NAME;
  logic [DW-1:0] commit_data_i = '0;
  logic [CW-1:0] hiwater_i = CW'(N);
  logic commit_ready_o, lookup_hit_o, flush_busy_o, evict_valid_o;
  logic [DW-1:0] lookup_data_o, evict_data_o;
  logic [NW-1:0] evict_addr_o;

  always #2 clk_i = ~clk_i;

  spill_value_store #(.NUM_ENTRIES(N), .NAME_W(NW), .DATA_W(DW)) i_spill_value_store (.*);

  int checks = 0, failures = 0, ev_cnt = 0;
  logic [NW-1:0] ev_last_addr = '0;
  logic [DW-1:0] ev_last_data = '0;

  always @(posedge clk_i) if (rst_ni && evict_valid_o && evict_ready_i) begin
    ev_cnt++;
    ev_last_addr <= evict_addr_o;
    ev_last_data <= evict_data_o;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; commit_valid_i = 0; kill_valid_i = 0; flush_req_i = 0;
    evict_ready_i = 1; lookup_name_i = IDLE_NAME; hiwater_i = CW'(N);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic do_commit(logic [15:0] n, logic [15:0] d);
    @(negedge clk_i);
    commit_valid_i = 1; commit_name_i = n; commit_data_i = d;
    @(posedge clk_i); #1;
    commit_valid_i = 0;
  endtask

  task automatic do_kill(logic [15:0] n);
    @(negedge clk_i);
    kill_valid_i = 1; kill_name_i = n;
    @(posedge clk_i); #1;
    kill_valid_i = 0;
  endtask

  task automatic do_lookup(string tag, logic [15:0] n, logic h, logic [15:0] d);
    @(negedge clk_i);
    lookup_name_i = n; #1;
    check({tag, " hit"}, 32'(lookup_hit_o), 32'(h));
    check({tag, " data"}, 32'(lookup_data_o), 32'(d));
    @(posedge clk_i); #1;
    lookup_name_i = IDLE_NAME;
  endtask

  // {op(0 commit,1 kill,2 lookup), name, data, exp_hit, exp_data}
  localparam logic [50:0] VECS [10] = '{
    {2'd0, 16'h0010, 16'h1111, 1'b0, 16'h0000},
    {2'd0, 16'h0020, 16'h2222, 1'b0, 16'h0000},
    {2'd2, 16'h0010, 16'h0000, 1'b1, 16'h1111},
    {2'd0, 16'h0020, 16'h2A2A, 1'b0, 16'h0000},
    {2'd2, 16'h0020, 16'h0000, 1'b1, 16'h2A2A},
    {2'd1, 16'h0010, 16'h0000, 1'b0, 16'h0000},
    {2'd2, 16'h0010, 16'h0000, 1'b0, 16'h0000},
    {2'd2, 16'h0099, 16'h0000, 1'b0, 16'h0000},
    {2'd0, 16'h0030, 16'h3333, 1'b0, 16'h0000},
    {2'd2, 16'h0030, 16'h0000, 1'b1, 16'h3333}
  };

  initial begin
    repeat (50000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    do_reset();
    @(negedge clk_i); #1;
    check("R10 lookup_hit", 32'(lookup_hit_o), 0);
    check("R10 evict_valid", 32'(evict_valid_o), 0);
    check("R10 flush_busy", 32'(flush_busy_o), 0);
    check("R10 commit_ready", 32'(commit_ready_o), 1);

    // table: R1 lookups, R2 allocation, R3 overwrite, R4 kill
    base = ev_cnt;
    for (int i = 0; i < 10; i++) begin
      case (VECS[i][50:49])
        2'd0: do_commit(VECS[i][48:33], VECS[i][32:17]);
        2'd1: do_kill(VECS[i][48:33]);
        default: do_lookup($sformatf("R1 vec%0d", i), VECS[i][48:33], VECS[i][16], VECS[i][15:0]);
      endcase
    end
    repeat (3) @(negedge clk_i);
    check("R2 R4 no memory writes in table", 32'(ev_cnt - base), 0);

    // R3: overwrite while full allocates nothing
    do_reset();
    for (int k = 1; k <= 4; k++) do_commit(16'(k), 16'(k) ^ 16'hA5A5);
    base = ev_cnt;
    do_commit(16'h0001, 16'hBEEF);
    repeat (3) @(negedge clk_i);
    check("R3 no eviction on overwrite", 32'(ev_cnt - base), 0);
    do_lookup("R3 new value", 16'h0001, 1'b1, 16'hBEEF);
    do_lookup("R3 others kept", 16'h0004, 1'b1, 16'h0004 ^ 16'hA5A5);

    // R6: LRU victim with recency from a lookup
    do_reset();
    for (int k = 1; k <= 4; k++) do_commit(16'(k), 16'(k) ^ 16'hA5A5);
    do_lookup("R6 touch", 16'h0001, 1'b1, 16'h0001 ^ 16'hA5A5);
    base = ev_cnt;
    do_commit(16'h0005, 16'h5555);
    repeat (3) @(negedge clk_i);
    check("R6 one eviction", 32'(ev_cnt - base), 1);
    check("R6 victim address", 32'(ev_last_addr), 32'h0002);
    check("R6 victim data", 32'(ev_last_data), 32'(16'h0002 ^ 16'hA5A5));
    do_lookup("R6 victim gone", 16'h0002, 1'b0, 16'h0000);
    do_lookup("R6 new present", 16'h0005, 1'b1, 16'h5555);

    // R7, R11: backpressure on the eviction port
    do_reset();
    evict_ready_i = 0;
    for (int k = 1; k <= 4; k++) do_commit(16'(k), 16'(k) ^ 16'hA5A5);
    base = ev_cnt;
    do_commit(16'h0005, 16'h5555);
    @(negedge clk_i);
    commit_valid_i = 1; commit_name_i = 16'h0006; commit_data_i = 16'h6666; #1;
    check("R7 ready low when blocked", 32'(commit_ready_o), 0);
    check("R11 word pending", 32'(evict_valid_o), 1);
    check("R11 pending address", 32'(evict_addr_o), 32'h0001);
    @(negedge clk_i); #1;
    check("R7 still stalled", 32'(commit_ready_o), 0);
    check("R11 address held", 32'(evict_addr_o), 32'h0001);
    evict_ready_i = 1; #1;
    check("R7 ready on accept", 32'(commit_ready_o), 1);
    @(posedge clk_i); #1;
    commit_valid_i = 0;
    repeat (3) @(negedge clk_i);
    check("R7 two evictions", 32'(ev_cnt - base), 2);
    check("R6 second victim", 32'(ev_last_addr), 32'h0002);
    do_lookup("R7 stalled commit landed", 16'h0006, 1'b1, 16'h6666);

    // R5: same-cycle commit and kill
    do_reset();
    do_commit(16'h0050, 16'h5050);
    base = ev_cnt;
    @(negedge clk_i);
    commit_valid_i = 1; commit_name_i = 16'h0050; commit_data_i = 16'h0BAD;
    kill_valid_i = 1; kill_name_i = 16'h0050;
    @(posedge clk_i); #1;
    commit_name_i = 16'h0060; kill_name_i = 16'h0060;
    @(posedge clk_i); #1;
    commit_valid_i = 0; kill_valid_i = 0;
    do_lookup("R5 present name gone", 16'h0050, 1'b0, 16'h0000);
    do_lookup("R5 new name gone", 16'h0060, 1'b0, 16'h0000);
    check("R5 no memory write", 32'(ev_cnt - base), 0);

    // R8: watermark early eviction
    do_reset();
    hiwater_i = CW'(2);
    base = ev_cnt;
    do_commit(16'h0031, 16'h3131);
    do_commit(16'h0032, 16'h3232);
    do_commit(16'h0033, 16'h3333);
    repeat (6) @(negedge clk_i);
    check("R8 exactly one early eviction", 32'(ev_cnt - base), 1);
    check("R8 oldest evicted", 32'(ev_last_addr), 32'h0031);
    do_lookup("R8 rest kept", 16'h0033, 1'b1, 16'h3333);

    // R9: flush
    do_reset();
    for (int k = 1; k <= 3; k++) do_commit(16'h0040 + 16'(k), 16'(k));
    base = ev_cnt;
    @(negedge clk_i);
    flush_req_i = 1;
    @(posedge clk_i); #1;
    flush_req_i = 0;
    commit_valid_i = 1; commit_name_i = 16'h0077; commit_data_i = 16'h7777;
    @(negedge clk_i); #1;
    check("R9 busy after request", 32'(flush_busy_o), 1);
    check("R9 commits refused", 32'(commit_ready_o), 0);
    commit_valid_i = 0;
    for (int w = 0; w < 50 && flush_busy_o; w++) @(negedge clk_i);
    check("R9 busy dropped", 32'(flush_busy_o), 0);
    check("R9 all drained", 32'(ev_cnt - base), 3);
    do_lookup("R9 entry gone", 16'h0042, 1'b0, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule